// File: doc/BRIEF.md
# Dual-Threshold Strip Cluster Finder

This block receives one corrected frame of strip amplitudes per event. The strips arrive one per accepted beat, in ascending channel order, and a start-of-frame marker flags channel 0. From these it builds zero-suppressed cluster records.

A cluster is made of neighbouring strips whose amplitudes exceed a low joining level. At least one of those strips must also exceed a higher seed level. Each record gives the first strip, the number of strips, every member amplitude, and the amplitude-weighted centre as an integer strip plus a 3-bit fraction. A one-threshold mode bypasses clustering and reports every qualifying strip by itself.

A per-channel mask silences noisy strips. A frame-level trigger-OR flag supports self-triggered running. On frames chosen by a programmable prescale, the raw frame is copied out alongside the suppressed data. Records wait in a small show-ahead FIFO that the consumer pops.

Top module: `strip_cluster_finder`

## Requirements
- R1: After reset, rec_valid, trig_or, ovf and nzs_valid are all low. A strip beat carrying in_sof is channel 0, and each later accepted beat is the next channel, up to NCH-1.
- R2: An unmasked strip is a member when its amplitude is strictly greater than incl_thr or strictly greater than seed_thr. A masked strip (chan_mask bit equal to its channel set) is never a member or a seed. A strip equal to a threshold does not pass it.
- R3: A candidate run of consecutive member strips produces a record only if it holds at least one seed, that is an unmasked strip strictly above seed_thr. A run without a seed is discarded.
- R4: A run closes when a non-member strip is accepted, and its record is written at that beat. A run that reaches channel NCH-1 closes at that last strip, and its record is written at that beat.
- R5: A run is capped at MAXC (4) strips. It closes and is written at its 4th strip, and the next member strip starts a new candidate.
- R6: Record fields: rec_first is the first strip and rec_size is the strip count. Member k sits in rec_amps[k*AW +: AW], and unused slots are zero. With q = floor(8·Σ(k·a_k)/Σa_k), rec_frac = q mod 8 and rec_cpos = rec_first + floor(q/8).
- R7: When simple_mode is high, every unmasked strip strictly above seed_thr is written as its own record at its own beat, with size 1, frac 0 and cpos equal to first.
- R8: trig_or rises on the edge after an unmasked strip above seed_thr is accepted and stays high to the end of the frame. The sof beat reloads it from that strip alone. A masked strip never sets it.
- R9: Frames are numbered from the first sof after reset. Frame n is selected when n mod (nzs_prescale+1) equals 0. For each strip of a selected frame, nzs_valid, nzs_amp and nzs_chan show the strip one cycle after it is accepted.
- R10: Records enter a 16-entry FIFO. rec_valid is high while the FIFO holds a record, with the oldest record on the outputs. A beat with rec_valid and rec_ready removes it, and an unpopped record stays unchanged.
- R11: A record that arrives while the FIFO holds 16 entries, judged before that cycle's pop, is dropped and sets ovf. Every later record of that frame is dropped. ovf is reloaded on the next sof beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strip beat accepted this cycle |
| in_sof | input | 1 | Beat is channel 0 of a new frame |
| in_amp | input | AW | Corrected strip amplitude |
| seed_thr | input | AW | Seed level |
| incl_thr | input | AW | Joining level |
| simple_mode | input | 1 | One-threshold, no-clustering mode |
| chan_mask | input | NCH | Per-channel noisy-strip mask |
| nzs_prescale | input | PSW | Raw-frame prescale |
| rec_valid | output | 1 | FIFO holds a record |
| rec_ready | input | 1 | Consumer pops the head record |
| rec_first | output | CW | First strip of the cluster |
| rec_size | output | LW | Strips in the cluster |
| rec_amps | output | MAXC*AW | Member amplitudes |
| rec_frac | output | 3 | Centre fraction in eighths |
| rec_cpos | output | CW | Integer centre strip |
| trig_or | output | 1 | Frame trigger-OR |
| ovf | output | 1 | Record dropped this frame |
| nzs_valid | output | 1 | Raw strip copy valid |
| nzs_amp | output | AW | Raw strip amplitude |
| nzs_chan | output | CW | Raw strip channel |

## Verification
The assertions take for granted that every frame is complete. Each frame opens with an sof beat and carries exactly NCH strips. The thresholds, mode, mask and prescale stay constant inside a frame. The stimulus streams only whole frames, with random idle gaps, and changes configuration only between frames, so no run ever spans a frame boundary.

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder #(
  parameter int NCH = 128,
  parameter int AW = 8,
  parameter int MAXC = 4,
  parameter int FDEPTH = 16,
  parameter int PSW = 8,
  localparam int CW = $clog2(NCH),
  localparam int LW = $clog2(MAXC + 1),
  localparam int FAW = $clog2(FDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [AW-1:0]     in_amp,
  input  logic [AW-1:0]     seed_thr,
  input  logic [AW-1:0]     incl_thr,
  input  logic              simple_mode,
  input  logic [NCH-1:0]    chan_mask,
  input  logic [PSW-1:0]    nzs_prescale,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [CW-1:0]     rec_first,
  output logic [LW-1:0]     rec_size,
  output logic [MAXC*AW-1:0] rec_amps,
  output logic [2:0]        rec_frac,
  output logic [CW-1:0]     rec_cpos,
  output logic              trig_or,
  output logic              ovf,
  output logic              nzs_valid,
  output logic [AW-1:0]     nzs_amp,
  output logic [CW-1:0]     nzs_chan
);
  localparam int SAW = AW + $clog2(MAXC) + 1;
  localparam int SIW = AW + 2 * LW;
  localparam int QW = SIW + 3;
  localparam int RW = 2 * CW + LW + MAXC * AW + 3;

  logic [CW-1:0] ch_q, ch;
  logic last, msk, is_seed, is_mem;

  assign ch = in_sof ? '0 : ch_q;
  assign last = (ch == CW'(NCH - 1));
  assign msk = chan_mask[ch];
  assign is_seed = !msk && (in_amp > seed_thr);
  assign is_mem = simple_mode ? is_seed : (is_seed || (!msk && (in_amp > incl_thr)));

  logic [LW-1:0] len_q, cur_len, n_len, e_len;
  logic [CW-1:0] first_q, n_first, e_first;
  logic [MAXC-1:0][AW-1:0] amps_q, n_amps, e_amps;
  logic seed_q, n_seed, e_seed;
  logic [SAW-1:0] sa_q, base_sa, n_sa, e_sa;
  logic [SIW-1:0] sia_q, base_sia, n_sia, e_sia;

  assign cur_len = in_sof ? '0 : len_q;
  assign n_len = cur_len + 1'b1;
  assign n_first = (cur_len == '0) ? ch : first_q;
  assign n_seed = ((cur_len != '0) && seed_q) || is_seed;
  assign base_sa = (cur_len == '0) ? '0 : sa_q;
  assign base_sia = (cur_len == '0) ? '0 : sia_q;
  assign n_sa = base_sa + SAW'(in_amp);
  assign n_sia = base_sia + SIW'(cur_len) * SIW'(in_amp);

  always_comb begin
    n_amps = (cur_len == '0) ? '0 : amps_q;
    for (int k = 0; k < MAXC; k++)
      if (LW'(k) == cur_len) n_amps[k] = in_amp;
  end

  logic close_ext, close_old, want, full, blk, push, pop;
  assign close_ext = is_mem && ((n_len == LW'(MAXC)) || last || simple_mode);
  assign close_old = !is_mem && (cur_len != '0);

  assign e_first = close_ext ? n_first : first_q;
  assign e_len   = close_ext ? n_len : len_q;
  assign e_amps  = close_ext ? n_amps : amps_q;
  assign e_seed  = close_ext ? n_seed : seed_q;
  assign e_sa    = close_ext ? n_sa : sa_q;
  assign e_sia   = close_ext ? n_sia : sia_q;

  logic [QW-1:0] qv;
  logic [CW-1:0] e_cpos;
  assign qv = (e_sa == '0) ? '0 : {e_sia, 3'b000} / QW'(e_sa);
  assign e_cpos = e_first + CW'(qv >> 3);

  logic ovf_q;
  logic [FAW:0] cnt_q;
  logic [FAW-1:0] wr_q, rd_q;
  logic [RW-1:0] mem [FDEPTH];

  assign want = in_valid && (close_ext || close_old) && e_seed;
  assign full = (cnt_q == (FAW+1)'(FDEPTH));
  assign blk = full || (ovf_q && !in_sof);
  assign push = want && !blk;
  assign pop = rec_valid && rec_ready;

  assign rec_valid = (cnt_q != '0);
  assign {rec_first, rec_size, rec_amps, rec_frac, rec_cpos} = mem[rd_q];
  assign ovf = ovf_q;

  logic trig_q, sel_q, cur_sel, nzs_valid_q;
  logic [PSW-1:0] fcnt_q;
  logic [AW-1:0] nzs_amp_q;
  logic [CW-1:0] nzs_chan_q;
  assign cur_sel = in_sof ? (fcnt_q == '0) : sel_q;
  assign trig_or = trig_q;
  assign nzs_valid = nzs_valid_q;
  assign nzs_amp = nzs_amp_q;
  assign nzs_chan = nzs_chan_q;

  always_ff @(posedge clk)
    if (push) mem[wr_q] <= {e_first, e_len, e_amps, qv[2:0], e_cpos};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0; len_q <= '0; first_q <= '0; amps_q <= '0; seed_q <= 1'b0;
      sa_q <= '0; sia_q <= '0; trig_q <= 1'b0; ovf_q <= 1'b0;
      sel_q <= 1'b0; fcnt_q <= '0;
      nzs_valid_q <= 1'b0; nzs_amp_q <= '0; nzs_chan_q <= '0;
      cnt_q <= '0; wr_q <= '0; rd_q <= '0;
    end else begin
      if (in_valid) begin
        ch_q <= last ? '0 : ch + 1'b1;
        if (is_mem && !close_ext) begin
          len_q <= n_len; first_q <= n_first; amps_q <= n_amps;
          seed_q <= n_seed; sa_q <= n_sa; sia_q <= n_sia;
        end else begin
          len_q <= '0;
        end
        trig_q <= in_sof ? is_seed : (trig_q || is_seed);
        ovf_q <= in_sof ? (want && full) : (ovf_q || (want && full));
        if (in_sof) begin
          sel_q <= (fcnt_q == '0);
          fcnt_q <= (fcnt_q >= nzs_prescale) ? '0 : fcnt_q + 1'b1;
        end
      end
      nzs_valid_q <= in_valid && cur_sel;
      nzs_amp_q <= in_amp;
      nzs_chan_q <= ch;
      if (push) wr_q <= (wr_q == FAW'(FDEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop) rd_q <= (rd_q == FAW'(FDEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10: cnt_q <= cnt_q + 1'b1;
        2'b01: cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/strip_cluster_finder_chk.sv
module strip_cluster_finder_chk #(
  parameter int NCH = 128,
  parameter int MAXC = 4,
  parameter int FDEPTH = 16,
  localparam int CW = $clog2(NCH),
  localparam int LW = $clog2(MAXC + 1),
  localparam int FAW = $clog2(FDEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [CW-1:0] rec_first,
  input logic [LW-1:0] rec_size,
  input logic [2:0]    rec_frac,
  input logic [CW-1:0] rec_cpos,
  input logic          trig_or,
  input logic          ovf,
  input logic          nzs_valid,
  input logic [FAW:0]  fifo_cnt
);
  a_r10_hold_unpopped: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_first) && $stable(rec_size)
      && $stable(rec_frac) && $stable(rec_cpos));

  a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= FDEPTH);

  a_r5_size_range: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_size != '0) && (int'(rec_size) <= MAXC));

  a_r6_centre_inside: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_cpos >= rec_first) && (int'(rec_cpos) < int'(rec_first) + int'(rec_size)));

  a_r11_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> int'($past(fifo_cnt)) == FDEPTH);

  a_r9_nzs_follows_strip: assert property (@(posedge clk) disable iff (!rst_n)
    nzs_valid |-> $past(in_valid));

  a_r8_trig_from_strip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_or) |-> $past(in_valid));
endmodule

bind strip_cluster_finder strip_cluster_finder_chk #(.NCH(NCH), .MAXC(MAXC), .FDEPTH(FDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_first(rec_first), .rec_size(rec_size), .rec_frac(rec_frac), .rec_cpos(rec_cpos),
  .trig_or(trig_or), .ovf(ovf), .nzs_valid(nzs_valid), .fifo_cnt(cnt_q)
);

// File: tb/strip_cluster_finder_tb_top.sv
module strip_cluster_finder_tb_top;
  localparam int NCH = 128, AW = 8, MAXC = 4, FD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 0, in_sof = 0, simple_mode = 0, rec_ready = 0;
  logic [AW-1:0] in_amp = '0, seed_thr = '0, incl_thr = '0;
  logic [NCH-1:0] chan_mask = '0;
  logic [7:0] nzs_prescale = '0;
  logic rec_valid, trig_or, ovf, nzs_valid;
  logic [6:0] rec_first, rec_cpos, nzs_chan;
  logic [2:0] rec_size, rec_frac;
  logic [MAXC*AW-1:0] rec_amps;
  logic [AW-1:0] nzs_amp;

  strip_cluster_finder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_amp(in_amp),
    .seed_thr(seed_thr), .incl_thr(incl_thr), .simple_mode(simple_mode), .chan_mask(chan_mask),
    .nzs_prescale(nzs_prescale), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_first(rec_first), .rec_size(rec_size), .rec_amps(rec_amps), .rec_frac(rec_frac),
    .rec_cpos(rec_cpos), .trig_or(trig_or), .ovf(ovf), .nzs_valid(nzs_valid),
    .nzs_amp(nzs_amp), .nzs_chan(nzs_chan));

  typedef struct { int first; int size; int frac; int cpos; logic [31:0] amps; } rec_t;
  rec_t mq[$];
  rec_t log_q[$];
  rec_t sched[NCH];
  bit sched_v[NCH];
  int famp[NCH];
  bit logging = 0;
  int checks = 0, fails = 0;
  int mch = 0, mfcnt = 0;
  bit movf = 0, mtrig = 0, msel = 0, exp_nv = 0;
  int exp_na = 0, exp_nc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_sd(int c);
    return !chan_mask[c] && famp[c] > int'(seed_thr);
  endfunction

  function automatic bit is_mb(int c);
    if (simple_mode) return is_sd(c);
    return !chan_mask[c] && (famp[c] > int'(incl_thr) || famp[c] > int'(seed_thr));
  endfunction

  task automatic build_sched();
    int i = 0;
    for (int c = 0; c < NCH; c++) sched_v[c] = 0;
    if (simple_mode) begin
      for (int c = 0; c < NCH; c++)
        if (is_mb(c)) begin
          rec_t r;
          r.first = c; r.size = 1; r.frac = 0; r.cpos = c; r.amps = 32'(famp[c]);
          sched[c] = r; sched_v[c] = 1;
        end
    end else begin
      while (i < NCH) begin
        if (!is_mb(i)) i++;
        else begin
          int s = i, len = 0, sa = 0, sia = 0, e, qv;
          bit sd = 0;
          logic [31:0] a = '0;
          while (i < NCH && is_mb(i) && len < MAXC) begin
            a[len*AW +: AW] = AW'(famp[i]);
            sa += famp[i]; sia += len * famp[i];
            if (is_sd(i)) sd = 1;
            len++; i++;
          end
          if (sd) begin
            rec_t r;
            e = (len == MAXC || i == NCH) ? i - 1 : i;
            qv = (8 * sia) / sa;
            r.first = s; r.size = len; r.frac = qv % 8; r.cpos = s + qv / 8; r.amps = a;
            sched[e] = r; sched_v[e] = 1;
          end
        end
      end
    end
  endtask

  task automatic model_step();
    bit full = (mq.size() == FD);
    if (rec_ready && mq.size() > 0) void'(mq.pop_front());
    if (in_valid) begin
      int c = in_sof ? 0 : mch;
      bit want = sched_v[c];
      bit blk = full || (movf && !in_sof);
      bit q = is_sd(c);
      if (want && !blk) mq.push_back(sched[c]);
      movf = in_sof ? (want && full) : (movf || (want && full));
      mtrig = in_sof ? q : (mtrig || q);
      if (in_sof) begin
        msel = (mfcnt == 0);
        mfcnt = (mfcnt >= int'(nzs_prescale)) ? 0 : mfcnt + 1;
      end
      exp_nv = msel; exp_na = famp[c]; exp_nc = c;
      mch = (c == NCH - 1) ? 0 : c + 1;
    end else exp_nv = 0;
  endtask

  task automatic compare();
    string ft = simple_mode ? "R7" : "R6";
    chk(rec_valid == (mq.size() != 0), "R10", "rec_valid", rec_valid, mq.size() != 0);
    if (rec_valid && mq.size() > 0) begin
      chk(int'(rec_first) == mq[0].first, ft, "rec_first", rec_first, mq[0].first);
      chk(int'(rec_size) == mq[0].size, ft, "rec_size", rec_size, mq[0].size);
      chk(int'(rec_frac) == mq[0].frac, ft, "rec_frac", rec_frac, mq[0].frac);
      chk(int'(rec_cpos) == mq[0].cpos, ft, "rec_cpos", rec_cpos, mq[0].cpos);
      chk(rec_amps == mq[0].amps, ft, "rec_amps", int'(rec_amps), int'(mq[0].amps));
    end
    chk(trig_or == mtrig, "R8", "trig_or", trig_or, mtrig);
    chk(ovf == movf, "R11", "ovf", ovf, movf);
    chk(nzs_valid == exp_nv, "R9", "nzs_valid", nzs_valid, exp_nv);
    if (nzs_valid && exp_nv) begin
      chk(int'(nzs_amp) == exp_na, "R9", "nzs_amp", nzs_amp, exp_na);
      chk(int'(nzs_chan) == exp_nc, "R9", "nzs_chan", nzs_chan, exp_nc);
    end
  endtask

  task automatic cycle();
    if (logging && rec_valid && rec_ready) begin
      rec_t r;
      r.first = rec_first; r.size = rec_size; r.frac = rec_frac; r.cpos = rec_cpos; r.amps = rec_amps;
      log_q.push_back(r);
    end
    @(posedge clk);
    model_step();
    #2;
    compare();
  endtask

  task automatic stream_frame(int gap_pct, int rdy_pct);
    build_sched();
    for (int c = 0; c < NCH; c++) begin
      while (int'($urandom % 100) < gap_pct) begin
        in_valid = 0; in_sof = 0;
        rec_ready = (int'($urandom % 100) < rdy_pct);
        cycle();
      end
      in_valid = 1; in_sof = (c == 0); in_amp = AW'(famp[c]);
      rec_ready = (int'($urandom % 100) < rdy_pct);
      cycle();
    end
    in_valid = 0; in_sof = 0;
  endtask

  task automatic drain();
    in_valid = 0; rec_ready = 1;
    for (int k = 0; k < 40; k++) if (rec_valid || mq.size() != 0) cycle();
    rec_ready = 0;
  endtask

  task automatic rand_frame();
    for (int c = 0; c < NCH; c++) begin
      int r = $urandom % 100;
      famp[c] = (r < 60) ? $urandom % 10 : (r < 85) ? 11 + $urandom % 29 : 41 + $urandom % 80;
    end
    chan_mask = '0;
    for (int k = 0; k < 4; k++) chan_mask[$urandom % NCH] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(!rec_valid, "R1", "reset rec_valid", rec_valid, 0);
    chk(!trig_or, "R1", "reset trig_or", trig_or, 0);
    chk(!ovf, "R1", "reset ovf", ovf, 0);
    chk(!nzs_valid, "R1", "reset nzs_valid", nzs_valid, 0);
    rst_n = 1;
    seed_thr = 40; incl_thr = 10; nzs_prescale = 1;

    // Handmade frame: R2 R3 R4 R5 R6
    for (int c = 0; c < NCH; c++) famp[c] = 0;
    chan_mask = '0; chan_mask[20] = 1'b1;
    famp[5] = 12; famp[6] = 50; famp[7] = 12;
    famp[10] = 20; famp[11] = 20;
    famp[19] = 45; famp[20] = 99; famp[21] = 45;
    famp[30] = 41; famp[31] = 10; famp[32] = 30; famp[33] = 30; famp[34] = 30; famp[35] = 30;
    famp[40] = 20; famp[41] = 20; famp[42] = 20; famp[43] = 50; famp[44] = 20; famp[45] = 20;
    famp[126] = 15; famp[127] = 60;
    logging = 1;
    stream_frame(0, 100);
    chk(trig_or == 1'b1, "R8", "trig after seeded frame", trig_or, 1);
    drain();
    logging = 0;
    chk(log_q.size() == 6, "R3", "record count", log_q.size(), 6);
    if (log_q.size() == 6) begin
      chk(log_q[0].cpos == 6 && log_q[0].frac == 0, "R6", "centre 5..7", log_q[0].cpos * 8 + log_q[0].frac, 48);
      chk(log_q[1].first == 19 && log_q[1].size == 1, "R2", "mask splits run", log_q[1].size, 1);
      chk(log_q[3].first == 30 && log_q[3].size == 1, "R2", "equal threshold excluded", log_q[3].size, 1);
      chk(log_q[4].first == 40 && log_q[4].size == 4, "R5", "capped size", log_q[4].size, 4);
      chk(log_q[4].frac == 7 && log_q[4].cpos == 41, "R6", "capped centre", log_q[4].cpos * 8 + log_q[4].frac, 335);
      chk(log_q[5].first == 126 && log_q[5].frac == 6, "R4", "frame-end cluster", log_q[5].first, 126);
    end

    // Masked high strip only: R8
    for (int c = 0; c < NCH; c++) famp[c] = 0;
    famp[20] = 200;
    stream_frame(10, 100);
    chk(trig_or == 1'b0, "R8", "masked strip no trigger", trig_or, 0);
    chk(rec_valid == 1'b0, "R2", "masked strip no record", rec_valid, 0);

    nzs_prescale = 2;
    for (int f = 0; f < 5; f++) begin
      rand_frame();
      stream_frame(20, 70);
    end
    drain();

    // Simple mode: R7
    simple_mode = 1; incl_thr = 5;
    rand_frame();
    log_q.delete();
    logging = 1;
    stream_frame(15, 80);
    drain();
    logging = 0;
    begin
      int bad = 0;
      foreach (log_q[k]) if (log_q[k].size != 1) bad++;
      chk(bad == 0 && log_q.size() > 0, "R7", "single-strip records", bad, 0);
    end
    simple_mode = 0; incl_thr = 10;

    // Overflow: R11
    chan_mask = '0;
    for (int c = 0; c < NCH; c++) famp[c] = (c % 2 == 0) ? 50 : 0;
    stream_frame(0, 0);
    chk(ovf == 1'b1, "R11", "ovf after flood", ovf, 1);
    chk(rec_valid == 1'b1, "R10", "fifo holds records", rec_valid, 1);
    for (int c = 0; c < NCH; c++) famp[c] = 0;
    stream_frame(0, 100);
    chk(ovf == 1'b0, "R11", "ovf cleared by next frame", ovf, 0);
    drain();
    chk(rec_valid == 1'b0, "R10", "fifo empty after drain", rec_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule